// File: doc/BRIEF.md
# Programmable Sum-of-Products Core with Cluster Steering

This block is the logic core of one programmable sum-of-products slice. Twenty-six input signals feed an AND plane that builds 68 product terms. Sixty-four of them are general terms. They are grouped four to a cluster, which gives sixteen clusters. A static steering field sends each cluster to at most one of sixteen sum outputs, and each sum output ORs together every cluster it receives. The other four terms are not steered. They come out directly as two output-enable terms, an asynchronous-clear term and an asynchronous-set term. The macrocells that consume these outputs sit outside the block.

A sum output can only take clusters from a small window of adjacent cluster indices near its own index. One sum can therefore gather up to sixteen terms, but only by taking clusters that its neighbours could otherwise use. A steering code that points a cluster outside the target's window is ignored.

All configuration arrives on a one-bit serial chain. Bits shift in while a load strobe is high. Every logic output stays low until a complete configuration has been shifted in and the strobe has dropped.

Top module: `pla_sop_core`

## Requirements
- R1: After reset, every sum, output-enable, clear and set output is 0, whatever the inputs are, until a complete configuration has been loaded.
- R2: One configuration bit shifts in on each rising clock edge while `cfgLoad` is 1. Chain bit 0 is sent first and chain bit 3615 is sent last. A load restarts its count when `cfgLoad` rises. All outputs are 0 while `cfgLoad` is 1, and they stay 0 after a load that shifted fewer than 3616 bits.
- R3: Product term t uses chain bits t*52+2i and t*52+2i+1 for input i. The first bit requires input i to be 1, and the second requires it to be 0. A term with no bits set is 1. A term that has both bits set for one input is always 0.
- R4: Sum output m is the OR of all product terms in the clusters legally steered to m. Cluster c holds terms 4c to 4c+3.
- R5: The steering field of cluster c sits at chain bits 3536+5c to 3536+5c+4. Bit 0 of the field is the enable, and bits 4:1 are the target sum index. The steering counts only if c lies in the window base..base+3 of the target m, where base = min(max(m-1,0),12). An out-of-window code contributes nothing.
- R6: A disabled cluster contributes 0, and a sum output that receives no cluster is 0.
- R7: One sum output can combine four clusters, which is sixteen product terms. Any one of those terms being 1 drives the sum to 1.
- R8: Term 64 drives `oeTerm[0]`, term 65 drives `oeTerm[1]`, term 66 drives `arTerm` and term 67 drives `apTerm`. These four terms never feed any sum.
- R9: While `cfgLoad` is 0, `cfgIn` has no effect, the configuration is held, and the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Shift strobe for the configuration chain |
| cfgIn | input | 1 | Serial configuration data |
| pinIn | input | 26 | Logic inputs to the AND plane |
| sumOut | output | 16 | Sum inputs for the sixteen macrocells |
| oeTerm | output | 2 | Two output-enable product terms |
| arTerm | output | 1 | Asynchronous-clear product term |
| apTerm | output | 1 | Asynchronous-set product term |

## Verification
The hardest situation to reach from the ports is a single sum output that collects a full sixteen terms, each term waking up on a different input, while another cluster with an always-true term is aimed at that same sum from outside its window. Reaching it takes a complete 3616-bit load built for that purpose. A directed configuration sets up exactly this case. One-hot input sweeps then show that every one of the sixteen terms lifts the sum on its own, and an all-zero input shows that the illegal cluster cannot lift it. Further random configurations, with steering biased toward legal windows and clipped at both ends, are checked against a reference model in the bench while `cfgIn` toggles with the strobe low.

// File: rtl/pla_sop_core_pkg.sv
package pla_sop_core_pkg;

  // Strobes from the load control to the datapath
  typedef struct packed {
    logic shiftEn;  // shift one configuration bit this cycle
    logic outEn;    // a full configuration is present; release outputs
  } cfg_strobe_t;

endpackage

// File: rtl/pla_cfg_ctrl.sv
module pla_cfg_ctrl
  import pla_sop_core_pkg::*;
#(
  parameter int TOTAL_BITS = 3616
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgLoad,
  output cfg_strobe_t strobe
);

  localparam int CW = $clog2(TOTAL_BITS + 1);

  logic [CW-1:0] bitCnt;
  logic          loadPrev;
  logic          cntFull;

  assign cntFull = (bitCnt == CW'(TOTAL_BITS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= '0;
      loadPrev <= 1'b0;
    end else begin
      loadPrev <= cfgLoad;
      if (cfgLoad) begin
        if (!loadPrev) bitCnt <= CW'(1);
        else if (!cntFull) bitCnt <= bitCnt + CW'(1);
      end
    end
  end

  always_comb begin
    strobe.shiftEn = cfgLoad;
    strobe.outEn   = !cfgLoad && cntFull;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CW'(TOTAL_BITS)) else $error("count overflow"); // R2
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgLoad) |=> (bitCnt == CW'(1))) else $error("no restart"); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(bitCnt)) else $error("count moved"); // R9

endmodule

// File: rtl/pla_alloc.sv
module pla_alloc #(
  parameter int N_LOGIC = 64,
  parameter int CL_SIZE = 4,
  parameter int N_MC    = 16,
  parameter int WIN     = 4
) (
  input  logic [N_LOGIC-1:0]                              ptLogic,
  input  logic [(N_LOGIC/CL_SIZE)*($clog2(N_MC)+1)-1:0] steerBits,
  output logic [N_MC-1:0]                                 sumRaw
);

  localparam int N_CL    = N_LOGIC / CL_SIZE;
  localparam int MC_W    = $clog2(N_MC);
  localparam int STEER_W = MC_W + 1;
  localparam int MAX_BASE = N_CL - WIN;

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    localparam int BASE_LO = (m > 0) ? m - 1 : 0;
    localparam int BASE    = (BASE_LO > MAX_BASE) ? MAX_BASE : BASE_LO;
    logic [WIN-1:0] take;
    for (genvar w = 0; w < WIN; w++) begin : g_win
      localparam int C = BASE + w;
      logic clEn;
      logic clHit;
      assign clEn  = steerBits[C*STEER_W];
      assign clHit = steerBits[C*STEER_W+1 +: MC_W] == MC_W'(m);
      assign take[w] = clEn && clHit && (|ptLogic[C*CL_SIZE +: CL_SIZE]);
    end
    assign sumRaw[m] = |take;
  end

endmodule

// File: rtl/pla_datapath.sv
module pla_datapath
  import pla_sop_core_pkg::*;
#(
  parameter int N_IN    = 26,
  parameter int N_LOGIC = 64,
  parameter int CL_SIZE = 4,
  parameter int N_MC    = 16,
  parameter int WIN     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  cfg_strobe_t     strobe,
  input  logic            cfgIn,
  input  logic [N_IN-1:0] pinIn,
  output logic [N_MC-1:0] sumOut,
  output logic [1:0]      oeTerm,
  output logic            arTerm,
  output logic            apTerm
);

  localparam int N_SPEC     = 4;
  localparam int N_TERMS    = N_LOGIC + N_SPEC;
  localparam int N_CL       = N_LOGIC / CL_SIZE;
  localparam int MC_W       = $clog2(N_MC);
  localparam int STEER_W    = MC_W + 1;
  localparam int TERM_W     = 2 * N_IN;
  localparam int ARRAY_BITS = N_TERMS * TERM_W;
  localparam int TOTAL_BITS = ARRAY_BITS + N_CL * STEER_W;

  logic [TOTAL_BITS-1:0]     cfgReg;
  logic [N_TERMS-1:0]        ptVal;
  logic [N_CL*STEER_W-1:0]   steerBits;
  logic [N_CL-1:0]           steerEn;
  logic [N_MC-1:0]           sumRaw;

  // Serial chain: newest bit enters at the top, first bit ends at bit 0
  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else if (strobe.shiftEn) cfgReg <= {cfgIn, cfgReg[TOTAL_BITS-1:1]};
  end

  // AND plane
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [TERM_W-1:0] conn;
    logic [N_IN-1:0]   veto;
    assign conn = cfgReg[t*TERM_W +: TERM_W];
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign veto[i] = (conn[2*i] & ~pinIn[i]) | (conn[2*i+1] & pinIn[i]);
    end
    assign ptVal[t] = ~|veto;
  end

  assign steerBits = cfgReg[ARRAY_BITS +: N_CL*STEER_W];
  for (genvar c = 0; c < N_CL; c++) begin : g_en
    assign steerEn[c] = steerBits[c*STEER_W];
  end

  pla_alloc #(
    .N_LOGIC(N_LOGIC), .CL_SIZE(CL_SIZE), .N_MC(N_MC), .WIN(WIN)
  ) alloc_i (
    .ptLogic  (ptVal[N_LOGIC-1:0]),
    .steerBits(steerBits),
    .sumRaw   (sumRaw)
  );

  always_comb begin
    sumOut = strobe.outEn ? sumRaw : '0;
    oeTerm = strobe.outEn ? ptVal[N_LOGIC +: 2] : 2'b00;
    arTerm = strobe.outEn && ptVal[N_LOGIC+2];
    apTerm = strobe.outEn && ptVal[N_LOGIC+3];
  end

  AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.outEn |-> (sumOut == '0 && oeTerm == 2'b00 && !arTerm && !apTerm))
    else $error("outputs not gated"); // R2
  AST_NO_STEER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.outEn && steerEn == '0) |-> (sumOut == '0))
    else $error("sum without cluster"); // R6
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(cfgReg)) else $error("config moved"); // R9

endmodule

// File: rtl/pla_sop_core.sv
module pla_sop_core
  import pla_sop_core_pkg::*;
#(
  parameter int N_IN    = 26,
  parameter int N_LOGIC = 64,
  parameter int CL_SIZE = 4,
  parameter int N_MC    = 16,
  parameter int WIN     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgLoad,
  input  logic            cfgIn,
  input  logic [N_IN-1:0] pinIn,
  output logic [N_MC-1:0] sumOut,
  output logic [1:0]      oeTerm,
  output logic            arTerm,
  output logic            apTerm
);

  localparam int N_CL       = N_LOGIC / CL_SIZE;
  localparam int STEER_W    = $clog2(N_MC) + 1;
  localparam int TOTAL_BITS = (N_LOGIC + 4) * 2 * N_IN + N_CL * STEER_W;

  cfg_strobe_t strobe;

  pla_cfg_ctrl #(.TOTAL_BITS(TOTAL_BITS)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .cfgLoad(cfgLoad),
    .strobe (strobe)
  );

  pla_datapath #(
    .N_IN(N_IN), .N_LOGIC(N_LOGIC), .CL_SIZE(CL_SIZE), .N_MC(N_MC), .WIN(WIN)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .cfgIn (cfgIn),
    .pinIn (pinIn),
    .sumOut(sumOut),
    .oeTerm(oeTerm),
    .arTerm(arTerm),
    .apTerm(apTerm)
  );

endmodule

// File: tb/pla_sop_core_tb_top.sv
module pla_sop_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_IN       = 26;
  localparam int N_LOGIC    = 64;
  localparam int CL_SIZE    = 4;
  localparam int N_MC       = 16;
  localparam int WIN        = 4;
  localparam int N_CL       = N_LOGIC / CL_SIZE;
  localparam int MC_W       = 4;
  localparam int STEER_W    = MC_W + 1;
  localparam int TERM_W     = 2 * N_IN;
  localparam int ARRAY_BITS = (N_LOGIC + 4) * TERM_W;
  localparam int TOTAL_BITS = ARRAY_BITS + N_CL * STEER_W;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cfgLoad = 1'b0;
  logic            cfgIn = 1'b0;
  logic [N_IN-1:0] pinIn = '0;
  logic [N_MC-1:0] sumOut;
  logic [1:0]      oeTerm;
  logic            arTerm;
  logic            apTerm;

  int errCnt = 0;
  int chkCnt = 0;
  logic [TOTAL_BITS-1:0] cfgShadow;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_sop_core dut_i (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgIn(cfgIn), .pinIn(pinIn),
    .sumOut(sumOut), .oeTerm(oeTerm), .arTerm(arTerm), .apTerm(apTerm)
  );

  function automatic int baseOf(int m);
    int b = (m > 0) ? m - 1 : 0;
    return (b > N_CL - WIN) ? N_CL - WIN : b;
  endfunction

  function automatic logic termVal(int t, logic [N_IN-1:0] x);
    for (int i = 0; i < N_IN; i++) begin
      if (cfgShadow[t*TERM_W + 2*i] && !x[i]) return 1'b0;
      if (cfgShadow[t*TERM_W + 2*i + 1] && x[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [N_MC-1:0] expSums(logic [N_IN-1:0] x);
    logic [N_MC-1:0] r = '0;
    for (int c = 0; c < N_CL; c++) begin
      int tgt = int'(cfgShadow[ARRAY_BITS + c*STEER_W + 1 +: MC_W]);
      if (cfgShadow[ARRAY_BITS + c*STEER_W] &&
          c >= baseOf(tgt) && c < baseOf(tgt) + WIN)
        for (int k = 0; k < CL_SIZE; k++)
          if (termVal(c*CL_SIZE + k, x)) r[tgt] = 1'b1;
    end
    return r;
  endfunction

  task automatic setConn(int t, int i, logic tru, logic cmp);
    cfgShadow[t*TERM_W + 2*i]     = tru;
    cfgShadow[t*TERM_W + 2*i + 1] = cmp;
  endtask

  task automatic setSteer(int c, logic en, int mc);
    cfgShadow[ARRAY_BITS + c*STEER_W] = en;
    cfgShadow[ARRAY_BITS + c*STEER_W + 1 +: MC_W] = MC_W'(mc);
  endtask

  task automatic checkZero(string tag);
    chkCnt++;
    if (sumOut !== '0 || oeTerm !== 2'b00 || arTerm !== 1'b0 || apTerm !== 1'b0) begin
      errCnt++;
      $display("FAIL %s gated outputs actual=%h/%b/%b/%b expected=0", tag,
               sumOut, oeTerm, arTerm, apTerm);
    end
  endtask

  // Bench drives at the falling edge; one rising edge shifts each bit
  task automatic loadCfg(int nBits);
    @(negedge clk);
    cfgLoad = 1'b1;
    for (int k = 0; k < nBits; k++) begin
      cfgIn = cfgShadow[k];
      if (k == 100) begin
        #1 checkZero("R2 during load");
      end
      @(negedge clk);
    end
    cfgLoad = 1'b0;
    cfgIn   = 1'b0;
  endtask

  task automatic applyCheck(logic [N_IN-1:0] x, string tag, logic wiggle);
    logic [N_MC-1:0] es;
    logic [1:0]      eo;
    @(negedge clk);
    pinIn = x;
    if (wiggle) cfgIn = 1'($urandom);
    #1;
    es = expSums(x);
    eo = {termVal(N_LOGIC+1, x), termVal(N_LOGIC, x)};
    chkCnt++;
    if (sumOut !== es || oeTerm !== eo || arTerm !== termVal(N_LOGIC+2, x) ||
        apTerm !== termVal(N_LOGIC+3, x)) begin
      errCnt++;
      $display("FAIL %s pins=%h actual=%h/%b/%b/%b expected=%h/%b/%b/%b", tag, x,
               sumOut, oeTerm, arTerm, apTerm, es, eo,
               termVal(N_LOGIC+2, x), termVal(N_LOGIC+3, x));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errCnt++;
    chkCnt++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    cfgShadow = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: after reset nothing is released
    for (int v = 0; v < 3; v++) begin
      @(negedge clk);
      pinIn = N_IN'($urandom);
      #1 checkZero("R1 after reset");
    end

    // R2: short load stays gated (all-empty terms would otherwise give 1s)
    loadCfg(TOTAL_BITS - 1);
    @(negedge clk);
    #1 checkZero("R2 short load");

    // R3 R6 R8: empty terms are 1, no steering gives zero sums
    loadCfg(TOTAL_BITS);
    applyCheck('0, "R3 R6 R8 empty terms", 1'b0);
    applyCheck('1, "R3 R6 empty terms ones", 1'b0);

    // R4 R5 R7: sixteen terms on sum 5, illegal clusters aimed at 5 and 14
    cfgShadow = '0;
    for (int t = 16; t < 32; t++) setConn(t, t - 16, 1'b1, 1'b0);
    for (int c = 4; c < 8; c++) setSteer(c, 1'b1, 5);
    setSteer(0, 1'b1, 5);            // out of window, terms always 1
    setSteer(11, 1'b1, 14);          // out of window, terms always 1
    setSteer(15, 1'b1, 15);          // clipped window top end
    setSteer(1, 1'b1, 0);            // clipped window bottom end
    for (int t = 4; t < 8; t++) setConn(t, 25, 1'b1, 1'b0);
    setConn(N_LOGIC, 20, 1'b1, 1'b0);
    setConn(N_LOGIC+1, 20, 1'b0, 1'b1);
    setConn(N_LOGIC+2, 3, 1'b1, 1'b1);   // both polarities: always 0
    loadCfg(TOTAL_BITS);
    applyCheck('0, "R5 illegal cluster ignored", 1'b0);
    for (int j = 0; j < 16; j++) applyCheck(N_IN'(1) << j, "R7 one of sixteen terms", 1'b0);
    applyCheck(N_IN'(1) << 20, "R8 oe polarity", 1'b0);
    applyCheck(N_IN'(1) << 25, "R5 clipped bottom", 1'b0);
    applyCheck(N_IN'(1) << 3, "R3 both bits zero", 1'b0);

    // R4 R5 R9: random configurations, cfgIn toggling with strobe low
    for (int cfgN = 0; cfgN < 5; cfgN++) begin
      for (int t = 0; t < N_LOGIC + 4; t++)
        for (int i = 0; i < N_IN; i++) begin
          int r = int'($urandom % 40);
          setConn(t, i, r == 0 || r == 39, r == 1 || r == 39);
        end
      for (int c = 0; c < N_CL; c++) begin
        int tgt = c - 2 + int'($urandom % 4);
        if ($urandom % 5 == 0) tgt = int'($urandom % N_MC);
        if (tgt < 0) tgt = 0;
        if (tgt > N_MC - 1) tgt = N_MC - 1;
        setSteer(c, ($urandom % 4) != 0, tgt);
      end
      loadCfg(TOTAL_BITS);
      for (int v = 0; v < 150; v++)
        applyCheck(N_IN'($urandom) & N_IN'($urandom | $urandom),
                   "R4 R9 random", 1'b1);
    end

    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule